// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a two-wire bus slave that behaves like a 2 KB byte-wide serial memory. A fast system clock samples the open-drain clock and data lines through synchronisers. The block finds START and STOP conditions and shifts in a control byte, a word address and data bytes, one bit per bus clock pulse. It acknowledges each byte it accepts by pulling the data line low through the ninth pulse. On a read it shifts memory bytes back out, most significant bit first.

Written bytes go into a sixteen-byte page buffer. The buffer is copied into the inferred memory array during a simulated programming cycle of fixed length. That cycle starts on the STOP that closes a write carrying data. The block has only one output, `sda_oe`. When it is high, an external open-drain driver pulls the data line low.

Top module: `ee_i2c_slave`

## Requirements
- R1: A falling data line while the clock is high is a START. A rising data line while the clock is high is a STOP. A START at any point, including in the middle of a byte, drops the current transfer and restarts control-byte reception. Write data whose STOP never arrives is not committed.
- R2: A control byte whose upper nibble is not binary 1010 gets no acknowledge, and the slave then ignores the bus until the next START.
- R3: Every accepted byte is acknowledged by holding the data line low through the high phase of the ninth clock pulse. The slave changes its drive only while the clock is low.
- R4: Control-byte bits 3..1 select one of eight 256-byte banks. The 11-bit write address is that bank number followed by the 8-bit word-address byte.
- R5: Data bytes fill a sixteen-byte page. Bits 3..0 of the address advance with each byte and wrap inside the page, so the last sixteen bytes sent are kept and a seventeenth byte overwrites the oldest one.
- R6: A STOP that ends a write with at least one data byte starts a programming cycle of PROG_CYCLES system clocks, after which the buffered bytes are in memory. A STOP after a write with no data byte starts no cycle.
- R7: While a programming cycle runs, the slave acknowledges nothing.
- R8: Control-byte bit 0 set to 1 means read. A read starts at the bank from the control byte combined with the low 8 bits of the current pointer. Each byte the master acknowledges advances the full 11-bit pointer, which wraps from 2047 to 0.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and keeps it released until the next START.
- R10: After reset the data line is released, the slave is idle and no programming cycle is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled level of the bus clock line |
| sda_in | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | High to pull the data line low |

## Verification
The page commit and the reception of a new control byte can run at the same time. The commit writes one buffered slot per system clock near the end of the programming cycle, while the bus front end may be decoding a START and control byte. The bench provokes this by polling with a write control byte immediately after every STOP that closes a write. It expects at least one poll to go unacknowledged and a later poll to be acknowledged. It then reads the whole page back and compares it with a model that applies in-page wrap and slot overwrite. A read that returns an old byte, or an acknowledge given during the cycle, shows that the two paths interfered.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACKW,
        S_ACK,
        S_TX,
        S_MACK
    } st_e;

    typedef enum logic [1:0] {
        K_CTRL,
        K_ADDR,
        K_DATA
    } kind_e;
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sr_q <= {scl_sr_q[STAGES-2:0], scl_in};
            sda_sr_q <= {sda_sr_q[STAGES-2:0], sda_in};
            scl_p_q  <= scl_sr_q[STAGES-1];
            sda_p_q  <= sda_sr_q[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sr_q[STAGES-1];
    assign sda_lvl   = sda_sr_q[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_p_q;
    assign scl_fall  = ~scl_lvl & scl_p_q;
    // data edges only count while the clock stayed high across both samples
    assign start_det = scl_lvl & scl_p_q & sda_p_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_p_q & ~sda_p_q & sda_lvl;
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave #(
    parameter int MEM_BYTES   = 2048,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 400   // must be at least PAGE_BYTES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    import ee_i2c_pkg::*;

    localparam int AW    = $clog2(MEM_BYTES);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int BLK_W = AW - 8;
    localparam int PCW   = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        st_e                         st;
        kind_e                       kind;
        logic [2:0]                  cnt;
        logic [7:0]                  sh;
        logic                        rd;
        logic                        mack;
        logic                        oe;
        logic [BLK_W-1:0]            blk;
        logic [AW-1:0]               ptr;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
        logic [PAGE_BYTES-1:0]       pval;
        logic                        wrote;
        logic                        busy;
        logic [PCW-1:0]              pcnt;
    } ctl_t;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    ctl_t q, d;

    logic [PW-1:0] wslot;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    rdata;
    st_e           cur_st;
    logic          prog_busy;

    ee_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // commit one page slot per clock during the last PAGE_BYTES cycles
    assign wslot     = q.pcnt[PW-1:0];
    assign mem_we    = q.busy && (q.pcnt < PCW'(PAGE_BYTES)) && q.pval[wslot];
    assign mem_waddr = {q.ptr[AW-1:PW], wslot};

    ee_mem_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (q.pbuf[wslot]),
        .raddr (q.ptr),
        .rdata (rdata)
    );

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.pcnt == '0) d.busy = 1'b0;
            else              d.pcnt = q.pcnt - PCW'(1);
        end

        if (start_det) begin
            d.st    = S_RX;
            d.kind  = K_CTRL;
            d.cnt   = '0;
            d.oe    = 1'b0;
            d.wrote = 1'b0;
        end else if (stop_det) begin
            d.st  = S_IDLE;
            d.oe  = 1'b0;
            if (q.wrote && !q.busy) begin
                d.busy = 1'b1;
                d.pcnt = PCW'(PROG_CYCLES - 1);
            end
            d.wrote = 1'b0;
        end else begin
            case (q.st)
                S_RX: if (scl_rise) begin
                    d.sh  = {q.sh[6:0], sda_lvl};
                    d.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) d.st = S_ACKW;
                end
                S_ACKW: if (scl_fall) begin
                    case (q.kind)
                        K_CTRL: begin
                            if (q.sh[7:4] == 4'b1010 && !q.busy) begin
                                d.oe  = 1'b1;
                                d.st  = S_ACK;
                                d.rd  = q.sh[0];
                                d.blk = q.sh[BLK_W:1];
                                if (q.sh[0]) d.ptr = {q.sh[BLK_W:1], q.ptr[7:0]};
                            end else begin
                                d.st = S_IDLE;
                            end
                        end
                        K_ADDR: begin
                            d.oe   = 1'b1;
                            d.st   = S_ACK;
                            d.ptr  = {q.blk, q.sh};
                            d.pval = '0;
                        end
                        default: begin
                            d.oe                      = 1'b1;
                            d.st                      = S_ACK;
                            d.pbuf[q.ptr[PW-1:0]]     = q.sh;
                            d.pval[q.ptr[PW-1:0]]     = 1'b1;
                            d.ptr[PW-1:0]             = q.ptr[PW-1:0] + PW'(1);
                            d.wrote                   = 1'b1;
                        end
                    endcase
                end
                S_ACK: if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rd) begin
                        d.st = S_TX;
                        d.sh = rdata;
                        d.oe = ~rdata[7];
                    end else begin
                        d.st   = S_RX;
                        d.oe   = 1'b0;
                        d.kind = (q.kind == K_CTRL) ? K_ADDR : K_DATA;
                    end
                end
                S_TX: if (scl_fall) begin
                    if (q.cnt == 3'd7) begin
                        d.oe = 1'b0;
                        d.st = S_MACK;
                    end else begin
                        d.cnt = q.cnt + 3'd1;
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.oe  = ~q.sh[6];
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                        if (!sda_lvl) d.ptr = q.ptr + AW'(1);
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = S_TX;
                            d.cnt = '0;
                            d.sh  = rdata;
                            d.oe  = ~rdata[7];
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe    = q.oe;
    assign cur_st    = q.st;
    assign prog_busy = q.busy;
endmodule

module ee_i2c_chk #(
    parameter int PROG_CYCLES = 400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input logic              prog_busy,
    input ee_i2c_pkg::st_e   cur_st
);
    int busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         busy_len_q <= 0;
        else if (prog_busy) busy_len_q <= busy_len_q + 1;
        else                busy_len_q <= 0;
    end

    // R3
    drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R7
    silent_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !sda_oe);

    // R6
    prog_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> $past(stop_det));

    // R6
    prog_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> (busy_len_q == PROG_CYCLES));

    // R1
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (cur_st == ee_i2c_pkg::S_RX));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ee_i2c_pkg::S_IDLE) |-> !sda_oe);
endmodule

bind ee_i2c_slave ee_i2c_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .prog_busy (prog_busy),
    .cur_st    (cur_st)
);

// File: tb/ee_i2c_slave_tb.sv
module ee_i2c_slave_tb;
    localparam int Q    = 4;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    logic [7:0] ref_mem [2048];
    bit         known   [2048];

    assign sda_line = ~(m_low | sda_oe);

    always #4 clk = ~clk;

    ee_i2c_slave #(.MEM_BYTES(2048), .PAGE_BYTES(16), .PROG_CYCLES(PROG)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl),
        .sda_in (sda_line),
        .sda_oe (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // address that the k-th data byte of a write lands on (in-page wrap)
    function automatic int slot_addr(input int base, input int k);
        return (base & 11'h7F0) | ((base + k) & 15);
    endfunction

    function automatic int seq_addr(input int base, input int k);
        return (base + k) % 2048;
    endfunction

    task automatic bus_start();
        tick(Q); m_low = 1'b0; tick(Q); scl = 1'b1;
        tick(2*Q); m_low = 1'b1; tick(2*Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_low = 1'b1; tick(Q); scl = 1'b1;
        tick(2*Q); m_low = 1'b0; tick(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_low = ~b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        end
        tick(1); m_low = 1'b0; tick(2*Q-1); scl = 1'b1;
        tick(Q); ack = ~sda_line; tick(Q); scl = 1'b0;
    endtask

    task automatic rd_byte(input bit give, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(2*Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
        end
        tick(Q); m_low = give; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        tick(1); m_low = 1'b0;
    endtask

    task automatic do_write(input int blk, input int word, input int len);
        bit ack;
        int base;
        logic [7:0] dat;
        logic [7:0] pend [32];
        base = blk * 256 + word;
        bus_start();
        wr_byte({4'hA, blk[2:0], 1'b0}, ack);
        chk(ack, "R3 write control ack", ack, 1);
        wr_byte(word[7:0], ack);
        chk(ack, "R4 word address ack", ack, 1);
        for (int k = 0; k < len; k++) begin
            dat = 8'($urandom);
            pend[k] = dat;
            wr_byte(dat, ack);
        end
        bus_stop();
        for (int k = 0; k < len; k++) begin
            ref_mem[slot_addr(base, k)] = pend[k];
            known[slot_addr(base, k)]   = 1'b1;
        end
    endtask

    task automatic poll_ready(output int nacks);
        bit ack;
        nacks = 0;
        forever begin
            bus_start();
            wr_byte(8'hA0, ack);
            bus_stop();
            if (ack || nacks > 60) break;
            nacks++;
        end
    endtask

    task automatic do_read(input int blk, input int word, input int len, input string req);
        bit ack;
        int base;
        logic [7:0] b;
        base = blk * 256 + word;
        bus_start();
        wr_byte({4'hA, blk[2:0], 1'b0}, ack);
        wr_byte(word[7:0], ack);
        bus_start();
        wr_byte({4'hA, blk[2:0], 1'b1}, ack);
        chk(ack, "R8 read control ack", ack, 1);
        for (int k = 0; k < len; k++) begin
            rd_byte(k != len - 1, b);
            if (known[seq_addr(base, k)])
                chk(b === ref_mem[seq_addr(base, k)], req, b, ref_mem[seq_addr(base, k)]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        int nacks;
        int blk, word, len;
        void'($urandom(32'd1234));
        for (int a = 0; a < 2048; a++) known[a] = 1'b0;

        // R10 reset state
        tick(10);
        chk(sda_oe == 1'b0, "R10 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(10);
        chk(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);
        poll_ready(nacks);
        chk(nacks == 0, "R10 not busy after reset", nacks, 0);

        // R2 wrong device code
        bus_start();
        wr_byte(8'hB0, ack);
        chk(!ack, "R2 foreign code nack", ack, 0);
        wr_byte(8'h00, ack);
        chk(!ack, "R2 ignored until START", ack, 0);
        bus_stop();

        // R6 address-only write starts no cycle
        bus_start();
        wr_byte(8'hA0, ack);
        wr_byte(8'h10, ack);
        bus_stop();
        poll_ready(nacks);
        chk(nacks == 0, "R6 no cycle without data", nacks, 0);

        // random writes with page read-back (R4, R5, R7, R6)
        for (int it = 0; it < 5; it++) begin
            blk  = int'($urandom % 8);
            word = int'($urandom % 256);
            len  = 1 + int'($urandom % 20);
            do_write(blk, word, len);
            poll_ready(nacks);
            chk(nacks >= 1, "R7 nack during programming", nacks, 1);
            chk(nacks <= 60, "R6 cycle completes", nacks, 60);
            do_read(blk, word & 8'hF0, 16, "R5 R4 page read-back");
        end

        // R5 directed overflow: 20 bytes, first four overwritten
        do_write(3, 8'h25, 20);
        poll_ready(nacks);
        do_read(3, 8'h20, 16, "R5 overwrite oldest");

        // R8 sequential read wraps 2047 -> 0
        do_write(7, 8'hFE, 2);
        poll_ready(nacks);
        do_write(0, 8'h00, 1);
        poll_ready(nacks);
        do_read(7, 8'hFE, 3, "R8 pointer wrap");

        // R1 START in the middle of a data byte aborts the write
        do_write(2, 8'h40, 1);
        poll_ready(nacks);
        bus_start();
        wr_byte(8'hA4, ack);
        wr_byte(8'h40, ack);
        for (int i = 0; i < 4; i++) begin
            tick(Q); m_low = 1'b1; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        end
        bus_start();
        wr_byte(8'hA4, ack);
        chk(ack, "R1 control accepted after restart", ack, 1);
        bus_stop();
        poll_ready(nacks);
        chk(nacks == 0, "R1 aborted write not programmed", nacks, 0);
        do_read(2, 8'h40, 1, "R1 memory unchanged after abort");

        // R9 master nack releases the line
        bus_start();
        wr_byte(8'hA5, ack);
        rd_byte(1'b0, word[7:0]);
        tick(3*Q);
        chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        tick(Q); scl = 1'b1; tick(Q);
        chk(sda_line == 1'b1, "R9 line high on extra pulse", sda_line, 1);
        tick(Q); scl = 1'b0;
        bus_stop();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule